// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block links two 9-bit buses, an A side and a B side. Each bus word holds 8 data bits and one parity bit. Each direction has its own latch and latch enable, and its own active-low output enable. A latch enable that is high makes its latch transparent. When the enable goes low, the latch keeps the last word it took in. The model is synchronous: the latch stores its input on every rising clock edge while the enable is high. The output path is transparent, so it follows the input in the same cycle.

A mode input sets what happens to the outgoing parity bit. In generate mode a fresh parity bit replaces it, computed from the eight latched data bits. In feed-through mode the received parity bit passes along with the data. A global sense input selects even or odd parity. Each direction checks the word held in its own latch and drives an active-low error output. When only one side is driven and the opposite latch is open, the driven word loops back into that latch. The error output of the far side then reports a second check of the word actually sent.

Tri-state pads appear as separate input, output and output-enable ports. The error outputs stay valid whether or not a bus is driven.

Top module: `par_xcvr`

## Requirements
- R1: Every bus word places parity at bit 8 and data at bits 7:0. With the A-to-B latch open and A not driven, b_out[7:0] equals a_in[7:0], and a_out relates to b_in in the same way.
- R2: While a latch enable is high, its output follows its input in the same cycle. After the enable falls, the output holds the word stored at the last rising clock edge with the enable high, and later input changes have no effect.
- R3: With feed_sel = 1, the outgoing parity bit equals the received parity bit held in that direction's latch.
- R4: With feed_sel = 0, the outgoing parity bit is the XOR of the 8 latched data bits when odd_sel = 0 (even parity over 9 bits). It is the inverse of that XOR when odd_sel = 1 (odd parity over 9 bits).
- R5: err_a_n is low exactly when the A-to-B latch word (latched data plus the received parity bit) has an even count of ones while odd_sel = 1, or an odd count while odd_sel = 0. When that latch is closed, the held word is checked, not a_in.
- R6: err_b_n applies the rule of R5 to the B-to-A latch word.
- R7: When oe_ab_n = 0 and oe_ba_n = 1, the B-to-A latch takes b_out instead of b_in. When oe_ba_n = 0 and oe_ab_n = 1, the A-to-B latch takes a_out instead of a_in. So with both latches open in generate mode, the far error output stays high.
- R8: b_oe = 1 exactly when oe_ab_n = 0, and a_oe = 1 exactly when oe_ba_n = 0. a_out, b_out and both error outputs are computed regardless of these enables.
- R9: When both output enables are low, each latch takes its own input port: A-to-B from a_in, B-to-A from b_in.
- R10: Reset (rst_n low) clears both held latch words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that stores latch contents |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 9 | Word seen at the A pads, parity at bit 8 |
| a_out | output | 9 | Word driven toward the A pads |
| a_oe | output | 1 | A pad drive enable |
| b_in | input | 9 | Word seen at the B pads, parity at bit 8 |
| b_out | output | 9 | Word driven toward the B pads |
| b_oe | output | 1 | B pad drive enable |
| oe_ab_n | input | 1 | Active-low enable for driving B from the A-to-B path |
| oe_ba_n | input | 1 | Active-low enable for driving A from the B-to-A path |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| feed_sel | input | 1 | 1 = pass received parity, 0 = generate parity |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| err_a_n | output | 1 | Active-low parity error for the A-to-B latch word |
| err_b_n | output | 1 | Active-low parity error for the B-to-A latch word |

## Verification
The A-to-B direction is swept over all 256 data values. Each value is tried under both parity senses and both modes, each with a correct and a flipped parity bit. The sweep separates generated parity from passed parity, and a good check from a failed one. The loop-back check on the B side confirms that the far latch sees the sent word, not the pin input. A second 256-value sweep in the opposite direction shows that the two lanes are symmetric. Directed cases then hold one word in a closed latch while the input changes, to tell a held check from a live one. Other directed cases drive both buses at once, to confirm that each latch takes its own input port.

// File: rtl/pxcv_pkg.sv
package pxcv_pkg;

    typedef enum logic {
        PAR_GEN  = 1'b0,
        PAR_FEED = 1'b1
    } par_mode_e;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_e;

endpackage

// File: rtl/par_calc.sv
module par_calc
    import pxcv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd_sel,
    output logic              gen
);

    par_sense_e sense;

    always_comb begin
        sense = par_sense_e'(odd_sel);
        gen   = ^data;
        if (sense == SENSE_ODD) begin
            gen = ~gen;
        end
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import pxcv_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] pin_in,
    input  logic              odd_sel,
    input  logic              feed_sel,
    output logic [WORD_W-1:0] out_word,
    output logic [WORD_W-1:0] fb_word,
    output logic              err_n
);

    typedef struct packed {
        logic [WORD_W-1:0] held;
    } lane_st_t;

    lane_st_t          st_d;
    lane_st_t          st_q;
    logic [WORD_W-1:0] now_w;
    logic [WORD_W-1:0] pin_view;
    logic              gen_now;
    logic              gen_fb;
    par_mode_e         mode;

    always_comb begin
        st_d     = st_q;
        now_w    = st_q.held;
        pin_view = st_q.held;
        if (le) begin
            st_d.held = src;
            now_w     = src;
            pin_view  = pin_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    par_calc #(.DATA_W(DATA_W)) u_gen_now (
        .data    (now_w[DATA_W-1:0]),
        .odd_sel (odd_sel),
        .gen     (gen_now)
    );

    par_calc #(.DATA_W(DATA_W)) u_gen_fb (
        .data    (pin_view[DATA_W-1:0]),
        .odd_sel (odd_sel),
        .gen     (gen_fb)
    );

    always_comb begin
        mode = par_mode_e'(feed_sel);
        if (mode == PAR_FEED) begin
            out_word = now_w;
            fb_word  = pin_view;
        end else begin
            out_word = {gen_now, now_w[DATA_W-1:0]};
            fb_word  = {gen_fb, pin_view[DATA_W-1:0]};
        end
        err_n = (gen_now == now_w[DATA_W]);
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !$past(le)) |-> (out_word[DATA_W-1:0] == $past(out_word[DATA_W-1:0]))); // R2

endmodule

// File: rtl/par_xcvr.sv
module par_xcvr #(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_in,
    output logic [WORD_W-1:0] a_out,
    output logic              a_oe,
    input  logic [WORD_W-1:0] b_in,
    output logic [WORD_W-1:0] b_out,
    output logic              b_oe,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic              le_ab,
    input  logic              le_ba,
    input  logic              feed_sel,
    input  logic              odd_sel,
    output logic              err_a_n,
    output logic              err_b_n
);

    logic              drive_a_only;
    logic              drive_b_only;
    logic [WORD_W-1:0] ab_src;
    logic [WORD_W-1:0] ba_src;
    logic [WORD_W-1:0] ab_out;
    logic [WORD_W-1:0] ba_out;
    logic [WORD_W-1:0] ab_fb;
    logic [WORD_W-1:0] ba_fb;
    logic              ab_err_n;
    logic              ba_err_n;

    // Loop-back uses the far lane's view of its own pins, never the
    // near lane's output, so no combinational cycle exists.
    always_comb begin
        drive_a_only = !oe_ba_n && oe_ab_n;
        drive_b_only = !oe_ab_n && oe_ba_n;
        ab_src       = drive_a_only ? ba_fb : a_in;
        ba_src       = drive_b_only ? ab_fb : b_in;
    end

    xcvr_lane #(.DATA_W(DATA_W)) u_lane_ab (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (le_ab),
        .src      (ab_src),
        .pin_in   (a_in),
        .odd_sel  (odd_sel),
        .feed_sel (feed_sel),
        .out_word (ab_out),
        .fb_word  (ab_fb),
        .err_n    (ab_err_n)
    );

    xcvr_lane #(.DATA_W(DATA_W)) u_lane_ba (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (le_ba),
        .src      (ba_src),
        .pin_in   (b_in),
        .odd_sel  (odd_sel),
        .feed_sel (feed_sel),
        .out_word (ba_out),
        .fb_word  (ba_fb),
        .err_n    (ba_err_n)
    );

    always_comb begin
        b_out   = ab_out;
        a_out   = ba_out;
        b_oe    = !oe_ab_n;
        a_oe    = !oe_ba_n;
        err_a_n = ab_err_n;
        err_b_n = ba_err_n;
    end

    AST_FEED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_sel && le_ab && oe_ba_n) |-> (b_out == a_in)); // R3

    AST_GEN_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_sel |-> ((^b_out) == odd_sel)); // R4

    AST_LOOPBACK_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && oe_ba_n && le_ab && le_ba && !feed_sel) |-> err_b_n); // R7

    AST_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab_n && !oe_ba_n && le_ab && le_ba && feed_sel) |-> (b_out == a_in && a_out == b_in)); // R9

endmodule

// File: tb/par_xcvr_tb_top.sv
`timescale 1ns/1ps
module par_xcvr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] a_in = '0;
    logic [8:0] b_in = '0;
    logic [8:0] a_out;
    logic [8:0] b_out;
    logic       a_oe;
    logic       b_oe;
    logic       oe_ab_n = 1'b1;
    logic       oe_ba_n = 1'b1;
    logic       le_ab = 1'b0;
    logic       le_ba = 1'b0;
    logic       feed_sel = 1'b0;
    logic       odd_sel = 1'b0;
    logic       err_a_n;
    logic       err_b_n;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    par_xcvr dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (a_in),
        .a_out    (a_out),
        .a_oe     (a_oe),
        .b_in     (b_in),
        .b_out    (b_out),
        .b_oe     (b_oe),
        .oe_ab_n  (oe_ab_n),
        .oe_ba_n  (oe_ba_n),
        .le_ab    (le_ab),
        .le_ba    (le_ba),
        .feed_sel (feed_sel),
        .odd_sel  (odd_sel),
        .err_a_n  (err_a_n),
        .err_b_n  (err_b_n)
    );

    // {data[7:0], par, odd, feed, exp_b_out[8:0], exp_err_a_n}
    localparam logic [20:0] VEC [8] = '{
        {8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 1'b1},
        {8'h01, 1'b0, 1'b0, 1'b0, 9'h101, 1'b0},
        {8'h01, 1'b1, 1'b0, 1'b1, 9'h101, 1'b1},
        {8'hFF, 1'b0, 1'b1, 1'b0, 9'h1FF, 1'b0},
        {8'h0F, 1'b1, 1'b0, 1'b1, 9'h10F, 1'b0},
        {8'h80, 1'b0, 1'b1, 1'b1, 9'h080, 1'b1},
        {8'hA5, 1'b1, 1'b1, 1'b0, 9'h1A5, 1'b1},
        {8'h7F, 1'b0, 1'b0, 1'b1, 9'h07F, 1'b0}
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic ref_gen(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: held words are zero after reset
        chk("R10 b_out", b_out, 9'h000);
        chk("R10 a_out", a_out, 9'h000);
        chk("R10 err_a_n", {8'h0, err_a_n}, 9'h001);

        // Table walk, A-to-B driven, B-to-A latch closed
        oe_ab_n = 1'b0; oe_ba_n = 1'b1; le_ab = 1'b1; le_ba = 1'b0;
        foreach (VEC[i]) begin
            @(negedge clk);
            a_in     = {VEC[i][10], VEC[i][20:13]};
            odd_sel  = VEC[i][11];
            feed_sel = VEC[i][10] ? VEC[i][10] : VEC[i][10];
            feed_sel = VEC[i][10];
            odd_sel  = VEC[i][11];
            a_in     = {VEC[i][12], VEC[i][20:13]};
            odd_sel  = VEC[i][11];
            feed_sel = VEC[i][10];
            #1;
            chk("R3/R4 table b_out", b_out, VEC[i][9:1]);
            chk("R5 table err_a_n", {8'h0, err_a_n}, {8'h0, VEC[i][0]});
        end

        // A-to-B sweep with loop-back into the open B-to-A latch (R7)
        le_ba = 1'b1;
        b_in  = 9'h1FF;
        for (int d = 0; d < 256; d++) begin
            for (int m = 0; m < 8; m++) begin
                logic [7:0] dv;
                logic       odd;
                logic       feed;
                logic       corrupt;
                logic       good;
                logic       par;
                logic [8:0] exp_b;
                logic       exp_eb;
                dv      = d[7:0];
                odd     = m[0];
                feed    = m[1];
                corrupt = m[2];
                good    = ref_gen(dv, odd);
                par     = corrupt ? ~good : good;
                exp_b   = feed ? {par, dv} : {good, dv};
                exp_eb  = ((^exp_b[7:0]) ^ odd) == exp_b[8];
                @(negedge clk);
                a_in     = {par, dv};
                odd_sel  = odd;
                feed_sel = feed;
                #1;
                chk("R1/R3/R4 sweep b_out", b_out, exp_b);
                chk("R5 sweep err_a_n", {8'h0, err_a_n}, {8'h0, !corrupt});
                chk("R7 loop-back err_b_n", {8'h0, err_b_n}, {8'h0, exp_eb});
            end
        end

        // B-to-A sweep, generate mode (R6)
        oe_ab_n = 1'b1; oe_ba_n = 1'b0; le_ab = 1'b0; le_ba = 1'b1;
        feed_sel = 1'b0;
        for (int d = 0; d < 256; d++) begin
            logic odd;
            odd = d[0] ^ d[3];
            @(negedge clk);
            b_in    = {1'b0, d[7:0]};
            odd_sel = odd;
            #1;
            chk("R4 B-to-A a_out", a_out, {ref_gen(d[7:0], odd), d[7:0]});
            chk("R6 B-to-A err_b_n", {8'h0, err_b_n}, {8'h0, !ref_gen(d[7:0], odd)});
        end

        // R2/R5: hold a word, then change a_in with the latch closed
        oe_ab_n = 1'b0; oe_ba_n = 1'b1; le_ba = 1'b0;
        feed_sel = 1'b1; odd_sel = 1'b0;
        @(negedge clk);
        le_ab = 1'b1;
        a_in  = 9'h155;
        @(negedge clk);
        le_ab = 1'b0;
        a_in  = 9'h0AA;
        #1;
        chk("R2 held b_out", b_out, 9'h155);
        chk("R5 held err_a_n", {8'h0, err_a_n}, 9'h000);
        @(negedge clk);
        a_in = 9'h1C3;
        #1;
        chk("R2 still held b_out", b_out, 9'h155);

        // R8: enables off, outputs still computed
        oe_ab_n = 1'b1; oe_ba_n = 1'b1;
        #1;
        chk("R8 b_oe off", {8'h0, b_oe}, 9'h000);
        chk("R8 a_oe off", {8'h0, a_oe}, 9'h000);
        chk("R8 b_out undriven", b_out, 9'h155);
        chk("R8 err_a_n undriven", {8'h0, err_a_n}, 9'h000);

        // R9: both sides driven, each latch from its own port
        @(negedge clk);
        oe_ab_n = 1'b0; oe_ba_n = 1'b0; le_ab = 1'b1; le_ba = 1'b1;
        a_in = 9'h003; b_in = 9'h1F0;
        #1;
        chk("R8 b_oe on", {8'h0, b_oe}, 9'h001);
        chk("R8 a_oe on", {8'h0, a_oe}, 9'h001);
        chk("R9 b_out", b_out, 9'h003);
        chk("R9 a_out", a_out, 9'h1F0);
        chk("R9 err_a_n", {8'h0, err_a_n}, 9'h001);
        chk("R9 err_b_n", {8'h0, err_b_n}, 9'h000);

        // R10: reset clears a held word
        @(negedge clk);
        le_ab = 1'b0; le_ba = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R10 reset b_out", b_out, 9'h000);
        chk("R10 reset a_out", a_out, 9'h000);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule